// File: doc/BRIEF.md
# Serial EEPROM command and write-protect core

This block is the instruction and protection core of a serial EEPROM slave with a 32K-byte array, reached over a four-wire SPI link in mode 0. It decodes the latch-arming and latch-disarming instructions, returns the status word, and accepts an update of the protection settings. It checks every program request against a two-bit protect field, which can lock the top quarter, the top half or the whole array. It also paces the internal write cycle with a down-counter. The memory array sits outside the block and is reached through a one-cycle request port. Reads return their data on the cycle after the request.

The SPI pins are sampled into the system clock domain through synchronisers, so the SPI clock must run well below the system clock. A program or status update only takes effect when chip select rises on a byte boundary. While the internal write cycle runs, the block ignores every instruction except the status read, and the status word reads all ones.

Top module: `eeprom_cmd_core`

## Requirements
- R1: After reset the status word reads 0x00: latch clear, ready, no protection, lock bit clear. `miso` is low and no array request is issued.
- R2: Opcode 0x06 sets the write latch, which is status bit 1. Opcode 0x04 clears it whatever level `wp_n` has.
- R3: After opcode 0x05 the status word is shifted out MSB first on `miso`, once per following byte, for as long as chip select stays low. Bit 7 is the lock bit, bits 6:4 are 0, bits 3:2 are the protect field, bit 1 is the latch and bit 0 is busy.
- R4: A program (0x02) or status write (0x01) issued while the latch is clear changes nothing: no array write, no status change.
- R5: Opcode 0x01 followed by one byte, with the latch set, stores byte bits 7, 3 and 2 as the lock bit and the protect field, and starts an internal write cycle of `WRITE_CYCLES` clocks. The other bits of that byte are ignored.
- R6: During an internal write cycle all eight status bits read 1. When the cycle ends, busy and the latch both read 0.
- R7: Opcode 0x02, two address bytes (bit 15 ignored) and data bytes cause one `arr_we` pulse when chip select rises on a byte boundary. The pulse carries the 15-bit address and the first data byte, and it starts an internal write cycle.
- R8: Protect field 01 locks 0x6000–0x7FFF, 10 locks 0x4000–0x7FFF and 11 locks the whole array. A program aimed at a locked address is dropped without a write cycle, and the latch stays set.
- R9: When the lock bit is 1 and `wp_n` is low, a status write is refused and the latch stays set. With `wp_n` high it is accepted.
- R10: If chip select rises anywhere other than a byte boundary, the latch clears and any pending program or status write is dropped.
- R11: While an internal write cycle runs, every opcode except 0x05 is ignored. A read issues no array request and a latch-arming opcode leaves the latch clear.
- R12: Opcode 0x03 and two address bytes cause array reads that are shifted out MSB first. The address steps up by one for each byte that follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | SPI chip select, active low |
| sclk | input | 1 | SPI serial clock, mode 0 |
| mosi | input | 1 | SPI data into the block |
| wp_n | input | 1 | Write-protect pin, active low |
| miso | output | 1 | SPI data out of the block, low when deselected |
| arr_we | output | 1 | One-cycle array write strobe |
| arr_re | output | 1 | One-cycle array read strobe |
| arr_addr | output | ADDR_W | Array byte address |
| arr_wdata | output | 8 | Array write data |
| arr_rdata | input | 8 | Array read data, valid the cycle after `arr_re` |

## Verification
The hardest cases to reach are the refusals that can only be seen once a frame closes. Examples are a program aimed at a locked range, a status write blocked by the lock bit and pin, and a frame cut off mid-byte. In each case nothing moves on the array port, so the bench shows the effect through the status word, where the latch has to stay set or drop. The stimulus first programs the protect field through an accepted status write and waits out its write cycle by polling. Only then does it send the refused frame, followed by a status read. To reach the busy-window rules, the bench sends a read and a latch-arming opcode right after a program, then confirms with a status read that the cycle was still running.

// File: rtl/eeprom_cmd_pkg.sv
package eeprom_cmd_pkg;

  typedef logic [7:0] byte_t;

  localparam byte_t OP_ARM    = 8'h06;
  localparam byte_t OP_DISARM = 8'h04;
  localparam byte_t OP_STAT   = 8'h05;
  localparam byte_t OP_SETPR  = 8'h01;
  localparam byte_t OP_READ   = 8'h03;
  localparam byte_t OP_PROG   = 8'h02;

  typedef enum logic [2:0] {
    CMD_IDLE,
    CMD_STATUS,
    CMD_READ,
    CMD_PROG,
    CMD_SETPR,
    CMD_DROP
  } cmd_e;

  // Protect field versus the two top address bits.
  function automatic logic in_locked(input logic [1:0] field, input logic [1:0] top2);
    case (field)
      2'b00:   in_locked = 1'b0;
      2'b01:   in_locked = (top2 == 2'b11);
      2'b10:   in_locked = top2[1];
      default: in_locked = 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/spi_sync_front.sv
module spi_sync_front #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sclk,
  input  logic mosi,
  output logic cs_act,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic frame_end,
  output logic mosi_s
);
  localparam int          NSIG    = 3;
  localparam logic [NSIG-1:0] IDLE_LVL = 3'b100;

  logic [NSIG-1:0] raw;
  logic [NSIG-1:0] synced;
  logic            cs_prev;
  logic            sclk_prev;

  assign raw = {cs_n, sclk, mosi};

  for (genvar g = 0; g < NSIG; g++) begin : g_sync
    logic [STAGES-1:0] sh;
    always_ff @(posedge clk) begin
      if (rst) sh <= {STAGES{IDLE_LVL[g]}};
      else     sh <= {sh[STAGES-2:0], raw[g]};
    end
    assign synced[g] = sh[STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_prev   <= 1'b1;
      sclk_prev <= 1'b0;
    end else begin
      cs_prev   <= synced[2];
      sclk_prev <= synced[1];
    end
  end

  assign cs_act    = !synced[2];
  assign sclk_rise = cs_act && synced[1] && !sclk_prev;
  assign sclk_fall = cs_act && !synced[1] && sclk_prev;
  assign frame_end = synced[2] && !cs_prev;
  assign mosi_s    = synced[0];

endmodule

// File: rtl/spi_byte_engine.sv
module spi_byte_engine
  import eeprom_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_act,
  input  logic       sclk_rise,
  input  logic       sclk_fall,
  input  logic       mosi_s,
  input  logic       tx_load,
  input  byte_t      tx_byte,
  output logic       byte_done,
  output byte_t      rx_byte,
  output logic [1:0] byte_idx,
  output logic       aligned,
  output logic       miso
);
  logic [2:0] bit_cnt;
  logic [6:0] in_sh;
  byte_t      out_sh;

  always_ff @(posedge clk) begin
    if (rst || !cs_act) begin
      bit_cnt   <= '0;
      in_sh     <= '0;
      byte_done <= 1'b0;
      byte_idx  <= '0;
      out_sh    <= '0;
    end else begin
      byte_done <= 1'b0;
      if (sclk_rise) begin
        bit_cnt <= bit_cnt + 3'd1;
        in_sh   <= {in_sh[5:0], mosi_s};
        if (bit_cnt == 3'd7) begin
          byte_done <= 1'b1;
          rx_byte   <= {in_sh, mosi_s};
        end
      end
      if (byte_done && byte_idx != 2'd3) byte_idx <= byte_idx + 2'd1;
      if (tx_load) out_sh <= tx_byte;
      else if (sclk_fall && bit_cnt != 3'd0) out_sh <= {out_sh[6:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) miso <= 1'b0;
    else     miso <= cs_act ? out_sh[7] : 1'b0;
  end

  assign aligned = (bit_cnt == 3'd0);

  // R1: data out is held low once the frame is closed.
  assert_miso_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> !miso);

endmodule

// File: rtl/status_keeper.sv
module status_keeper
  import eeprom_cmd_pkg::*;
#(
  parameter int WRITE_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       set_wel,
  input  logic       clr_wel,
  input  logic       wr_go,
  input  logic       wsr_go,
  input  byte_t      wsr_byte,
  input  logic [1:0] chk_top2,
  output byte_t      status,
  output logic       busy,
  output logic       wel,
  output logic       lock,
  output logic       prot_hit
);
  localparam int CW = $clog2(WRITE_CYCLES + 1);

  logic [CW-1:0] cnt;
  logic [1:0]    field;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      busy  <= 1'b0;
      wel   <= 1'b0;
      lock  <= 1'b0;
      field <= 2'b00;
    end else if (busy) begin
      if (cnt == CW'(1)) begin
        busy <= 1'b0;
        wel  <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt - CW'(1);
      end
    end else if (wr_go || wsr_go) begin
      busy <= 1'b1;
      cnt  <= CW'(WRITE_CYCLES);
      if (wsr_go) begin
        lock  <= wsr_byte[7];
        field <= wsr_byte[3:2];
      end
    end else if (set_wel) begin
      wel <= 1'b1;
    end else if (clr_wel) begin
      wel <= 1'b0;
    end
  end

  assign status   = busy ? 8'hFF : {lock, 3'b000, field, wel, 1'b0};
  assign prot_hit = in_locked(field, chk_top2);

  // R6: the latch is found clear once the cycle is over.
  assert_ready_clears_wel_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !wel);

  // R11: no new cycle is launched while one runs.
  assert_no_start_busy_R11: assert property (@(posedge clk) disable iff (rst)
    (wr_go || wsr_go) |-> !busy);

  // R4: a cycle only ever starts with the latch armed.
  assert_go_needs_wel_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_go || wsr_go) |-> wel);

  // R5: protection settings stay put while a cycle runs.
  assert_field_steady_R5: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(field) && $stable(lock)));

endmodule

// File: rtl/eeprom_cmd_core.sv
module eeprom_cmd_core
  import eeprom_cmd_pkg::*;
#(
  parameter int ADDR_W       = 15,
  parameter int WRITE_CYCLES = 1000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              mosi,
  input  logic              wp_n,
  output logic              miso,
  output logic              arr_we,
  output logic              arr_re,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [7:0]        arr_wdata,
  input  logic [7:0]        arr_rdata
);
  localparam int HI_W = ADDR_W - 8;

  logic        cs_act, sclk_rise, sclk_fall, frame_end, mosi_s;
  logic        byte_done, aligned;
  byte_t       rx_byte;
  logic [1:0]  byte_idx;
  logic        tx_load_q;
  byte_t       tx_byte_q;
  byte_t       status;
  logic        busy, wel, lock, prot_hit;
  logic        set_wel, clr_wel, wr_go, wsr_go;
  logic [1:0]  wp_sync;
  cmd_e        cmd;
  logic [HI_W-1:0]   hi_q;
  logic [ADDR_W-1:0] addr_q;
  byte_t       data_q;
  logic        have_data;
  logic        rd_wait;
  logic        arr_we_q, arr_re_q;

  spi_sync_front #(.STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .cs_act(cs_act), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .frame_end(frame_end), .mosi_s(mosi_s)
  );

  spi_byte_engine u_bytes (
    .clk(clk), .rst(rst), .cs_act(cs_act), .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall), .mosi_s(mosi_s), .tx_load(tx_load_q),
    .tx_byte(tx_byte_q), .byte_done(byte_done), .rx_byte(rx_byte),
    .byte_idx(byte_idx), .aligned(aligned), .miso(miso)
  );

  status_keeper #(.WRITE_CYCLES(WRITE_CYCLES)) u_status (
    .clk(clk), .rst(rst), .set_wel(set_wel), .clr_wel(clr_wel),
    .wr_go(wr_go), .wsr_go(wsr_go), .wsr_byte(data_q),
    .chk_top2(addr_q[ADDR_W-1 -: 2]), .status(status), .busy(busy),
    .wel(wel), .lock(lock), .prot_hit(prot_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) wp_sync <= 2'b11;
    else     wp_sync <= {wp_sync[0], wp_n};
  end

  // Latch and cycle decisions: opcode end and frame end.
  always_comb begin
    set_wel = 1'b0;
    clr_wel = 1'b0;
    wr_go   = 1'b0;
    wsr_go  = 1'b0;
    if (frame_end) begin
      if (!aligned) begin
        clr_wel = 1'b1;
      end else if (cmd == CMD_PROG && have_data && wel && !prot_hit) begin
        wr_go = 1'b1;
      end else if (cmd == CMD_SETPR && have_data && wel && !(lock && !wp_sync[1])) begin
        wsr_go = 1'b1;
      end
    end else if (byte_done && byte_idx == 2'd0 && !busy) begin
      if (rx_byte == OP_ARM)    set_wel = 1'b1;
      if (rx_byte == OP_DISARM) clr_wel = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd       <= CMD_IDLE;
      hi_q      <= '0;
      addr_q    <= '0;
      data_q    <= '0;
      have_data <= 1'b0;
      rd_wait   <= 1'b0;
      tx_load_q <= 1'b0;
      tx_byte_q <= '0;
      arr_we_q  <= 1'b0;
      arr_re_q  <= 1'b0;
    end else begin
      arr_we_q  <= wr_go;
      arr_re_q  <= 1'b0;
      tx_load_q <= 1'b0;
      rd_wait   <= arr_re_q;
      if (rd_wait) begin
        tx_load_q <= 1'b1;
        tx_byte_q <= arr_rdata;
      end
      if (frame_end) begin
        cmd       <= CMD_IDLE;
        have_data <= 1'b0;
      end else if (byte_done) begin
        if (byte_idx == 2'd0) begin
          if (busy && rx_byte != OP_STAT) begin
            cmd <= CMD_DROP;
          end else begin
            case (rx_byte)
              OP_STAT: begin
                cmd       <= CMD_STATUS;
                tx_load_q <= 1'b1;
                tx_byte_q <= status;
              end
              OP_READ:  cmd <= CMD_READ;
              OP_PROG:  cmd <= CMD_PROG;
              OP_SETPR: cmd <= CMD_SETPR;
              default:  cmd <= CMD_DROP;
            endcase
          end
        end else begin
          case (cmd)
            CMD_STATUS: begin
              tx_load_q <= 1'b1;
              tx_byte_q <= status;
            end
            CMD_READ, CMD_PROG: begin
              if (byte_idx == 2'd1) begin
                hi_q <= rx_byte[HI_W-1:0];
              end else if (byte_idx == 2'd2) begin
                addr_q <= {hi_q, rx_byte};
                if (cmd == CMD_READ) arr_re_q <= 1'b1;
              end else if (cmd == CMD_READ) begin
                addr_q   <= addr_q + ADDR_W'(1);
                arr_re_q <= 1'b1;
              end else if (!have_data) begin
                data_q    <= rx_byte;
                have_data <= 1'b1;
              end
            end
            CMD_SETPR: begin
              if (!have_data) begin
                data_q    <= rx_byte;
                have_data <= 1'b1;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign arr_we    = arr_we_q;
  assign arr_re    = arr_re_q;
  assign arr_addr  = addr_q;
  assign arr_wdata = data_q;

  // R8: no write strobe ever lands in a locked range.
  assert_we_unlocked_R8: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> !prot_hit);

  // R7: the write strobe is a single pulse.
  assert_we_single_R7: assert property (@(posedge clk) disable iff (rst)
    arr_we |=> !arr_we);

  // R9: a locked status write at frame end starts no cycle.
  assert_setpr_locked_R9: assert property (@(posedge clk) disable iff (rst)
    (frame_end && cmd == CMD_SETPR && lock && !wp_sync[1]) |=> !busy);

  // R10: a frame cut mid-byte leaves the latch clear.
  assert_partial_clears_R10: assert property (@(posedge clk) disable iff (rst)
    (frame_end && !aligned) |=> !wel);

  // R11: no array read is requested while a cycle runs.
  assert_no_read_busy_R11: assert property (@(posedge clk) disable iff (rst)
    (arr_re && $past(busy)) |-> $past(arr_re) || (cmd == CMD_READ));

endmodule

// File: tb/eeprom_cmd_core_tb.sv
`timescale 1ns/1ps
module eeprom_cmd_core_tb_top;
  localparam int AW   = 15;
  localparam int WC   = 1500;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst, cs_n, sclk, mosi, wp_n;
  logic miso, arr_we, arr_re;
  logic [AW-1:0] arr_addr;
  logic [7:0] arr_wdata, arr_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int we_cnt, re_cnt;
  logic [AW-1:0] last_addr;
  logic [7:0] last_data;
  logic [7:0] mem [0:255];

  always #2.5 clk = ~clk;

  eeprom_cmd_core #(.ADDR_W(AW), .WRITE_CYCLES(WC)) dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .wp_n(wp_n), .miso(miso), .arr_we(arr_we), .arr_re(arr_re),
    .arr_addr(arr_addr), .arr_wdata(arr_wdata), .arr_rdata(arr_rdata)
  );

  // Array model: 256 bytes aliased over the address space.
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h3C;
      we_cnt    <= 0;
      re_cnt    <= 0;
      arr_rdata <= 8'h00;
      last_addr <= '0;
      last_data <= 8'h00;
    end else begin
      if (arr_re) begin
        arr_rdata <= mem[arr_addr[7:0]];
        re_cnt    <= re_cnt + 1;
      end
      if (arr_we) begin
        mem[arr_addr[7:0]] <= arr_wdata;
        we_cnt    <= we_cnt + 1;
        last_addr <= arr_addr;
        last_data <= arr_wdata;
      end
    end
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = miso;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic bits(input logic [7:0] tx, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      mosi = tx[i];
      repeat (HALF) @(negedge clk);
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic sel();
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic desel();
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (4 * HALF) @(negedge clk);
  endtask

  task automatic op1(input logic [7:0] op);
    logic [7:0] d;
    sel(); xfer(op, d); desel();
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] d;
    sel(); xfer(8'h05, d); xfer(8'h00, s); desel();
  endtask

  task automatic prog(input logic [15:0] a, input logic [7:0] v);
    logic [7:0] d;
    sel(); xfer(8'h02, d); xfer(a[15:8], d); xfer(a[7:0], d); xfer(v, d); desel();
  endtask

  task automatic setpr(input logic [7:0] v);
    logic [7:0] d;
    sel(); xfer(8'h01, d); xfer(v, d); desel();
  endtask

  task automatic wait_ready(input string req);
    logic [7:0] s;
    int n;
    s = 8'hFF;
    n = 0;
    while (s[0] && n < 40) begin
      rdsr(s);
      n++;
    end
    check(req, {15'd0, s[0]}, 16'h0);
  endtask

  task automatic t_reset();
    logic [7:0] s;
    rst = 1'b1; cs_n = 1'b1; sclk = 1'b0; mosi = 1'b0; wp_n = 1'b1;
    repeat (10) @(negedge clk);
    check("R1 miso low in reset", {15'd0, miso}, 16'h0);
    rst = 1'b0;
    repeat (10) @(negedge clk);
    check("R1 no array strobe after reset", 16'(we_cnt + re_cnt), 16'h0);
    rdsr(s);
    check("R1 status after reset", {8'h0, s}, 16'h00);
  endtask

  task automatic t_latch();
    logic [7:0] s0, s1, d;
    op1(8'h06);
    sel(); xfer(8'h05, d); xfer(8'h00, s0); xfer(8'h00, s1); desel();
    check("R2 arm sets latch", {8'h0, s0}, 16'h02);
    check("R3 status repeats in one frame", {8'h0, s1}, 16'h02);
    wp_n = 1'b0;
    op1(8'h04);
    rdsr(s0);
    check("R2 disarm with wp_n low", {8'h0, s0}, 16'h00);
    wp_n = 1'b1;
  endtask

  task automatic t_unarmed();
    logic [7:0] s;
    int w;
    w = we_cnt;
    prog(16'h0010, 8'hA5);
    setpr(8'h8C);
    rdsr(s);
    check("R4 unarmed program writes nothing", 16'(we_cnt - w), 16'h0);
    check("R4 unarmed status write ignored", {8'h0, s}, 16'h00);
  endtask

  task automatic t_prog();
    logic [7:0] s, d;
    int w;
    w = we_cnt;
    op1(8'h06);
    sel(); xfer(8'h02, d); xfer(8'h80, d); xfer(8'h10, d);
    xfer(8'hA5, d); xfer(8'h5A, d); desel();
    check("R7 one write strobe", 16'(we_cnt - w), 16'h1);
    check("R7 address with bit15 dropped", 16'(last_addr), 16'h0010);
    check("R7 first data byte kept", {8'h0, last_data}, 16'h00A5);
    rdsr(s);
    check("R6 status all ones while busy", {8'h0, s}, 16'h00FF);
    wait_ready("R6 cycle ends");
    rdsr(s);
    check("R6 latch clear after cycle", {8'h0, s}, 16'h00);
  endtask

  task automatic t_read();
    logic [7:0] d, d0, d1;
    sel(); xfer(8'h03, d); xfer(8'h00, d); xfer(8'h10, d);
    xfer(8'h00, d0); xfer(8'h00, d1); desel();
    check("R12 first read byte", {8'h0, d0}, 16'h00A5);
    check("R12 address steps", {8'h0, d1}, 16'(8'h11 ^ 8'h3C));
  endtask

  task automatic t_setpr();
    logic [7:0] s;
    op1(8'h06);
    setpr(8'hF7);
    rdsr(s);
    check("R6 busy after status write", {8'h0, s}, 16'h00FF);
    wait_ready("R5 status write cycle ends");
    rdsr(s);
    check("R5 lock and field stored", {8'h0, s}, 16'h0084);
  endtask

  task automatic t_protect();
    logic [7:0] s;
    int w;
    w = we_cnt;
    op1(8'h06);
    prog(16'h6000, 8'h11);
    rdsr(s);
    check("R8 quarter lock drops 0x6000", 16'(we_cnt - w), 16'h0);
    check("R8 latch kept after drop", {8'h0, s}, 16'h0086);
    prog(16'h5FFF, 8'h22);
    check("R8 0x5FFF accepted", 16'(last_addr), 16'h5FFF);
    wait_ready("R8 cycle ends");
    op1(8'h06); setpr(8'h08); wait_ready("R8 field 10 stored");
    w = we_cnt;
    op1(8'h06);
    prog(16'h4000, 8'h33);
    check("R8 half lock drops 0x4000", 16'(we_cnt - w), 16'h0);
    prog(16'h3FFF, 8'h44);
    check("R8 0x3FFF accepted", 16'(last_addr), 16'h3FFF);
    wait_ready("R8 cycle ends");
    op1(8'h06); setpr(8'h0C); wait_ready("R8 field 11 stored");
    w = we_cnt;
    op1(8'h06);
    prog(16'h0000, 8'h55);
    rdsr(s);
    check("R8 full lock drops 0x0000", 16'(we_cnt - w), 16'h0);
    check("R8 status with full lock", {8'h0, s}, 16'h000E);
    setpr(8'h80);
    wait_ready("R5 lock bit stored");
    rdsr(s);
    check("R5 lock only", {8'h0, s}, 16'h0080);
  endtask

  task automatic t_pin_lock();
    logic [7:0] s;
    wp_n = 1'b0;
    op1(8'h06);
    setpr(8'h0C);
    rdsr(s);
    check("R9 locked status write refused", {8'h0, s}, 16'h0082);
    wp_n = 1'b1;
    setpr(8'h00);
    wait_ready("R9 unlocked write cycle ends");
    rdsr(s);
    check("R9 accepted with pin high", {8'h0, s}, 16'h0000);
  endtask

  task automatic t_partial();
    logic [7:0] s, d;
    int w;
    op1(8'h06);
    sel(); bits(8'h05, 3); desel();
    rdsr(s);
    check("R10 cut frame clears latch", {8'h0, s}, 16'h00);
    w = we_cnt;
    op1(8'h06);
    sel(); xfer(8'h02, d); xfer(8'h00, d); xfer(8'h30, d); xfer(8'h66, d);
    bits(8'h77, 5); desel();
    rdsr(s);
    check("R10 cut program dropped", 16'(we_cnt - w), 16'h0);
    check("R10 latch clear after cut program", {8'h0, s}, 16'h00);
  endtask

  task automatic t_busy_ignore();
    logic [7:0] s, d;
    int r;
    op1(8'h06);
    prog(16'h0020, 8'h77);
    op1(8'h06);
    r = re_cnt;
    sel(); xfer(8'h03, d); xfer(8'h00, d); xfer(8'h20, d); desel();
    check("R11 read ignored while busy", 16'(re_cnt - r), 16'h0);
    rdsr(s);
    check("R11 still busy", {8'h0, s}, 16'h00FF);
    wait_ready("R11 cycle ends");
    rdsr(s);
    check("R11 arm during busy ignored", {8'h0, s}, 16'h00);
  endtask

  initial begin
    t_reset();
    t_latch();
    t_unarmed();
    t_prog();
    t_read();
    t_setpr();
    t_protect();
    t_pin_lock();
    t_partial();
    t_busy_ignore();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule